// File: doc/BRIEF.md
# Boot Source Selection Controller

This block decides which of two on-chip code regions the processor fetches from after it comes out of reset: the application region or the loader region. On a power-on reset it decodes a two-bit nonvolatile configuration field. The application region is chosen only for one configuration code, and every other code chooses the loader region. The chosen region drives a fetch base address.

Software can redirect the next boot while the chip runs. It writes a boot-select bit and asks for a CPU-only reset in the same register write. Both bits are accepted only while the protected-register unlock indication is high. A CPU-reset request leaves the block as a one-cycle pulse. The region output takes the new selection on that same edge, and the selection survives the CPU-only reset. Between reset events the region output does not move, even if software rewrites the boot-select bit or the configuration field changes.

Top module: `boot_src_ctrl`

## Requirements
- R1: While `por` is high with `cfg` equal to 2'b11, the next clock edge sets `region` to 0 (application), `rd_sel` to 0 and `fetch_base` to `APP_BASE`.
- R2: While `por` is high with `cfg` equal to 2'b00, 2'b01 or 2'b10, the next clock edge sets `region` to 1 (loader), `rd_sel` to 1 and `fetch_base` to `LDR_BASE`.
- R3: An accepted write with `wr_sel`=1 and `wr_rst`=1 raises `rst_req` on the next edge, and `region` becomes 1 on that same edge.
- R4: An accepted write with `wr_sel`=0 and `wr_rst`=1 raises `rst_req` on the next edge, and `region` becomes 0 on that same edge.
- R5: A write made while `unlock` is 0 is ignored: `rd_sel` keeps its value and `rst_req` stays 0.
- R6: `rst_req` is high for exactly one cycle per accepted reset write. `rd_rst` reads 1 during that cycle and 0 afterwards.
- R7: The boot selection is kept across a CPU-only reset, and `cfg` is consulted only while `por` is high. Changing `cfg` outside power-on reset has no effect on `region` or `rd_sel`.
- R8: An accepted write with `wr_rst`=0 updates `rd_sel` on the next edge and leaves `region` unchanged.
- R9: `fetch_base` is `APP_BASE` when `region` is 0 and `LDR_BASE` when `region` is 1, at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Synchronous power-on reset, active high |
| cfg | input | CFG_W | Nonvolatile boot configuration field |
| unlock | input | 1 | Protected-register unlock indication |
| wr_en | input | 1 | Control register write strobe |
| wr_sel | input | 1 | Boot-select value written (1 = loader) |
| wr_rst | input | 1 | CPU-reset request bit written |
| rst_req | output | 1 | One-cycle CPU-only reset request |
| region | output | 1 | Current fetch region (0 = application, 1 = loader) |
| fetch_base | output | ADDR_W | Fetch base address of the current region |
| rd_sel | output | 1 | Readback of the boot-select bit |
| rd_rst | output | 1 | Readback of the CPU-reset bit |

## Verification
The bench builds the block with `CFG_W`=2, `APP_CODE`=2'b11, `ADDR_W`=32, `APP_BASE`=0 and `LDR_BASE`=32'h0010_0000. With these values all four configuration codes can be driven during power-on reset, and the two base addresses differ in a single high bit, so a swapped region mapping shows up directly on `fetch_base`. The sequence covers locked writes, a select write without a reset, and a configuration change in mid-run. It also repeats the power-on reset after software has redirected the boot.

// File: rtl/boot_src_pkg.sv
package boot_src_pkg;

  typedef enum logic {
    REGION_APP = 1'b0,
    REGION_LDR = 1'b1
  } region_e;

  // Power-on decode: only the application code picks the application region.
  function automatic logic cfg_to_loader(input logic [7:0] cfg, input logic [7:0] app_code);
    return (cfg != app_code);
  endfunction

  function automatic logic [63:0] region_base(input logic rgn,
                                              input logic [63:0] app_base,
                                              input logic [63:0] ldr_base);
    return rgn ? ldr_base : app_base;
  endfunction

endpackage

// File: rtl/boot_cfg_decode.sv
module boot_cfg_decode #(
  parameter int CFG_W = 2,
  parameter logic [CFG_W-1:0] APP_CODE = '1
) (
  input  logic [CFG_W-1:0] cfg,
  output logic             por_ldr
);
  import boot_src_pkg::*;

  localparam int PAD_W = 8 - CFG_W;

  always_comb begin
    por_ldr = cfg_to_loader({{PAD_W{1'b0}}, cfg}, {{PAD_W{1'b0}}, APP_CODE});
  end
endmodule

// File: rtl/boot_sel_reg.sv
module boot_sel_reg (
  input  logic clk,
  input  logic por,
  input  logic por_ldr,
  input  logic unlock,
  input  logic wr_en,
  input  logic wr_sel,
  input  logic wr_rst,
  output logic sel_q,
  output logic req_q,
  output logic load,
  output logic load_sel
);
  logic wr_ok;

  assign wr_ok    = wr_en && unlock;
  assign load     = wr_ok && wr_rst;
  assign load_sel = wr_sel;

  always_ff @(posedge clk) begin
    if (por) begin
      sel_q <= por_ldr;
      req_q <= 1'b0;
    end else begin
      if (wr_ok) sel_q <= wr_sel;
      req_q <= load;
    end
  end

  // R5
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (por)
    (wr_en && !unlock) |=> (sel_q == $past(sel_q)) && !req_q);

  // R6
  req_single_pulse_chk: assert property (@(posedge clk) disable iff (por)
    (req_q && !load) |=> !req_q);
endmodule

// File: rtl/boot_region_hold.sv
module boot_region_hold (
  input  logic clk,
  input  logic por,
  input  logic por_ldr,
  input  logic load,
  input  logic load_sel,
  output logic region_q
);
  always_ff @(posedge clk) begin
    if (por)       region_q <= por_ldr;
    else if (load) region_q <= load_sel;
  end

  // R8
  region_stable_chk: assert property (@(posedge clk) disable iff (por)
    (!load) |=> $stable(region_q));

  // R3
  region_loads_chk: assert property (@(posedge clk) disable iff (por)
    (load && load_sel) |=> region_q);
endmodule

// File: rtl/boot_src_ctrl.sv
module boot_src_ctrl #(
  parameter int CFG_W = 2,
  parameter logic [CFG_W-1:0] APP_CODE = '1,
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] APP_BASE = '0,
  parameter logic [ADDR_W-1:0] LDR_BASE = ADDR_W'(32'h0010_0000)
) (
  input  logic              clk,
  input  logic              por,
  input  logic [CFG_W-1:0]  cfg,
  input  logic              unlock,
  input  logic              wr_en,
  input  logic              wr_sel,
  input  logic              wr_rst,
  output logic              rst_req,
  output logic              region,
  output logic [ADDR_W-1:0] fetch_base,
  output logic              rd_sel,
  output logic              rd_rst
);
  import boot_src_pkg::*;

  localparam int PAD_W = 64 - ADDR_W;

  logic por_ldr;
  logic sel_q, req_q, load, load_sel, region_q;
  logic [63:0] base_wide;

  boot_cfg_decode #(.CFG_W(CFG_W), .APP_CODE(APP_CODE)) u_dec (
    .cfg(cfg), .por_ldr(por_ldr)
  );

  boot_sel_reg u_sel (
    .clk(clk), .por(por), .por_ldr(por_ldr), .unlock(unlock),
    .wr_en(wr_en), .wr_sel(wr_sel), .wr_rst(wr_rst),
    .sel_q(sel_q), .req_q(req_q), .load(load), .load_sel(load_sel)
  );

  boot_region_hold u_rgn (
    .clk(clk), .por(por), .por_ldr(por_ldr),
    .load(load), .load_sel(load_sel), .region_q(region_q)
  );

  always_comb begin
    base_wide = region_base(region_q, {{PAD_W{1'b0}}, APP_BASE}, {{PAD_W{1'b0}}, LDR_BASE});
  end

  assign fetch_base = base_wide[ADDR_W-1:0];
  assign rst_req    = req_q;
  assign rd_rst     = req_q;
  assign rd_sel     = sel_q;
  assign region     = region_q;

  // R4
  region_app_on_reset_chk: assert property (@(posedge clk) disable iff (por)
    (wr_en && unlock && wr_rst && !wr_sel) |=> (rst_req && !region));

  // R7
  cfg_ignored_run_chk: assert property (@(posedge clk) disable iff (por)
    (!wr_en) |=> $stable(rd_sel) && $stable(region));
endmodule

// File: tb/boot_src_ctrl_tb_top.sv
module boot_src_ctrl_tb_top;
  localparam logic [31:0] APP_B = 32'h0000_0000;
  localparam logic [31:0] LDR_B = 32'h0010_0000;

  logic clk = 1'b0;
  logic por = 1'b1;
  logic [1:0] cfg = 2'b11;
  logic unlock = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, wr_rst = 1'b0;
  logic rst_req, region, rd_sel, rd_rst;
  logic [31:0] fetch_base;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  req;
    logic  rgn;
    logic  sel;
    string tag;
  } exp_t;
  exp_t q[$];

  always #2.5 clk = ~clk;

  boot_src_ctrl #(.CFG_W(2), .APP_CODE(2'b11), .ADDR_W(32),
                  .APP_BASE(APP_B), .LDR_BASE(LDR_B)) dut_i (
    .clk(clk), .por(por), .cfg(cfg), .unlock(unlock), .wr_en(wr_en),
    .wr_sel(wr_sel), .wr_rst(wr_rst), .rst_req(rst_req), .region(region),
    .fetch_base(fetch_base), .rd_sel(rd_sel), .rd_rst(rd_rst)
  );

  task automatic check(input string tag, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Driver: one cycle of stimulus, then the expected outputs after the edge.
  task automatic step(input logic p, input logic [1:0] c, input logic u, input logic w,
                      input logic s, input logic r, input logic e_req, input logic e_rgn,
                      input logic e_sel, input string tag);
    exp_t e;
    @(negedge clk);
    por = p; cfg = c; unlock = u; wr_en = w; wr_sel = s; wr_rst = r;
    @(posedge clk);
    e.req = e_req; e.rgn = e_rgn; e.sel = e_sel; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compare away from the active edge.
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        check(e.tag, "rst_req", {31'b0, rst_req}, {31'b0, e.req});
        check(e.tag, "rd_rst",  {31'b0, rd_rst},  {31'b0, e.req});
        check(e.tag, "region",  {31'b0, region},  {31'b0, e.rgn});
        check(e.tag, "rd_sel",  {31'b0, rd_sel},  {31'b0, e.sel});
        check({e.tag, "/R9"}, "fetch_base", fetch_base, e.rgn ? LDR_B : APP_B);
      end
    end
  end

  initial begin
    // R1: power-on with application code
    step(1, 2'b11, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 2'b11, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R2: each other code selects the loader
    for (int c = 0; c < 3; c++) begin
      step(1, 2'(c), 0, 0, 0, 0, 0, 1, 1, "R2");
    end
    step(0, 2'b01, 0, 0, 0, 0, 0, 1, 1, "R2");
    // R5: locked writes are ignored
    step(0, 2'b01, 0, 1, 0, 1, 0, 1, 1, "R5");
    step(0, 2'b01, 0, 1, 0, 0, 0, 1, 1, "R5");
    // R8: select write without reset keeps region
    step(0, 2'b01, 1, 1, 0, 0, 0, 1, 0, "R8");
    step(0, 2'b01, 1, 0, 0, 0, 0, 1, 0, "R8");
    // R4: reset write to application
    step(0, 2'b01, 1, 1, 0, 1, 1, 0, 0, "R4");
    // R6: pulse ends, readback clears
    step(0, 2'b01, 1, 0, 0, 0, 0, 0, 0, "R6");
    // R7: cfg change mid-run has no effect
    step(0, 2'b00, 0, 0, 0, 0, 0, 0, 0, "R7");
    // R3: reset write to loader
    step(0, 2'b11, 1, 1, 1, 1, 1, 1, 1, "R3");
    step(0, 2'b11, 1, 0, 0, 0, 0, 1, 1, "R6");
    step(0, 2'b11, 0, 0, 0, 0, 0, 1, 1, "R7");
    // R6: back-to-back reset writes, then a single idle cycle
    step(0, 2'b11, 1, 1, 0, 1, 1, 0, 0, "R6");
    step(0, 2'b11, 1, 1, 1, 1, 1, 1, 1, "R6");
    step(0, 2'b11, 0, 0, 0, 0, 0, 1, 1, "R6");
    // R1: power-on reloads from cfg after redirect
    step(1, 2'b11, 0, 0, 0, 0, 0, 0, 0, "R1");
    step(0, 2'b11, 0, 0, 0, 0, 0, 0, 0, "R1");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule